// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a write-through cache and memory. It keeps pending stores in a few block-sized entries. Each entry has a block address, one data word per word slot and a per-word valid mask. An incoming store is compared with every occupied entry that is not being written out. When the block address matches, the store is folded into that entry. Otherwise the store takes a free entry. When no entry matches and none is free, the store port stalls.

A single memory port carries both entry drains and read-miss fetches, one transaction at a time. Entries drain oldest first, and each drain is one block write that carries the entry's word mask. A pending read miss goes ahead of queued drains as soon as the current memory transaction completes. If the block being read is still buffered, that entry is written out first, so the fetched block always contains every store accepted before the read was requested.

Top module: `wbuf_merge`

## Requirements
- R1: After reset `st_ready` is 1, `mem_req` is 0 and `rd_done` is 0.
- R2: A store whose block address matches an occupied entry that is not draining is merged into that entry, so stores to one block produce a single memory write whose mask is the union of the words written (mask bit i stands for word i, the word held at `mem_wdata[32*i+31:32*i]`).
- R3: When a word that is already pending is stored again, the later data replaces the earlier data, and only the last value reaches memory.
- R4: A store to the block of the entry currently being drained is not merged. It takes a new entry and produces a separate later write. The write data and mask stay stable while a drain waits for its acknowledge.
- R5: `st_ready` is 0 when the store matches no mergeable entry and every entry is occupied. It is 1 when the store matches a mergeable entry, even when all entries are occupied.
- R6: With no read pending, entries drain in allocation order, oldest first. Each drain is exactly one memory write (`mem_we`=1) to the entry's block address, with the entry's word mask.
- R7: A read miss that hits no buffered block is issued on the memory port (`mem_we`=0) as the next transaction after the one in flight, ahead of all queued drains.
- R8: A read miss to a buffered block first drains that entry and then issues the read. `rd_data` then holds all stores accepted before the request.
- R9: `mem_req` stays high, with `mem_we` and `mem_addr` unchanged, until the cycle in which `mem_ack` is 1.
- R10: `rd_done` is a one-cycle pulse in the cycle after the read's `mem_ack`. `rd_data` holds the fetched block with word i in bits [32*i+31:32*i].
- R11: Over any mix of stores, merges and reads, once the buffer is empty the memory holds exactly the last value stored to every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted when high with st_valid |
| st_addr | input | ADDR_W | Store word address (block address above the word offset) |
| st_data | input | DATA_W | Store data |
| rd_req | input | 1 | Read miss request, held until rd_done |
| rd_addr | input | ADDR_W-log2(WORDS) | Read block address |
| rd_done | output | 1 | Read data valid pulse |
| rd_data | output | WORDS*DATA_W | Fetched block |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 for a drain write, 0 for a read |
| mem_addr | output | ADDR_W-log2(WORDS) | Memory block address |
| mem_wdata | output | WORDS*DATA_W | Drain write data |
| mem_wmask | output | WORDS | Word-valid mask of the drain write |
| mem_ack | input | 1 | Memory completes the current transaction |
| mem_rdata | input | WORDS*DATA_W | Memory read data, valid with mem_ack |

## Verification
Two functions can fall in the same cycle. A store can arrive for a block whose entry is already draining, and a read miss can arrive while writes are queued or while the read block is still buffered. The bench provokes both by holding the memory acknowledge low, so that one drain stays in flight while stores and a read are presented. It then releases the acknowledge. The bench judges the outcome from the memory-side transaction order, the masks and the read data, all computed from a reference image of memory that is updated at each accepted store.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_WR   = 2'd1,
    MS_RD   = 2'd2
  } mstate_t;
endpackage

// File: rtl/wbm_store.sv
module wbm_store #(
  parameter int ENTRIES = 4,
  parameter int WORDS   = 4,
  parameter int DATA_W  = 32,
  parameter int BADDR_W = 6,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    st_valid,
  input  logic [BADDR_W-1:0]      st_blk,
  input  logic [OFF_W-1:0]        st_word,
  input  logic [DATA_W-1:0]       st_data,
  output logic                    st_ready,
  input  logic                    drain_busy,
  input  logic [IDX_W-1:0]        drain_idx,
  input  logic                    free_en,
  input  logic [BADDR_W-1:0]      look_blk,
  output logic                    look_hit,
  output logic [IDX_W-1:0]        look_idx,
  output logic                    any_valid,
  output logic [IDX_W-1:0]        oldest_idx,
  input  logic [IDX_W-1:0]        out_idx,
  output logic [BADDR_W-1:0]      out_blk,
  output logic [WORDS*DATA_W-1:0] out_block,
  output logic [WORDS-1:0]        out_mask
);
  logic [ENTRIES-1:0] vld;
  logic [BADDR_W-1:0] blk_q  [ENTRIES];
  logic [WORDS-1:0]   msk_q  [ENTRIES];
  logic [IDX_W-1:0]   rank_q [ENTRIES];
  // word storage, one write port, addressed {entry, word}
  logic [DATA_W-1:0]  dat_q  [ENTRIES*WORDS];

  logic [ENTRIES-1:0] hit_vec, free_vec, look_vec, head_vec;
  logic [IDX_W-1:0]   hit_idx, alloc_idx;
  logic [CNT_W-1:0]   cnt_valid;
  logic               hit, st_fire, do_alloc;
  logic [WORDS-1:0]   st_onehot;
  logic [IDX_W-1:0]   new_rank, tgt_idx;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i]  = vld[i] && (blk_q[i] == st_blk) &&
                    !(drain_busy && (drain_idx == IDX_W'(i)));
      free_vec[i] = !vld[i];
      look_vec[i] = vld[i] && (blk_q[i] == look_blk);
      head_vec[i] = vld[i] && (rank_q[i] == '0);
    end
  end

  // lowest-index priority pick for each vector
  always_comb begin
    hit_idx = '0; alloc_idx = '0; look_idx = '0; oldest_idx = '0;
    cnt_valid = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i])  hit_idx    = IDX_W'(i);
      if (free_vec[i]) alloc_idx  = IDX_W'(i);
      if (look_vec[i]) look_idx   = IDX_W'(i);
      if (head_vec[i]) oldest_idx = IDX_W'(i);
    end
    for (int i = 0; i < ENTRIES; i++) cnt_valid = cnt_valid + CNT_W'(vld[i]);
  end

  assign hit       = |hit_vec;
  assign look_hit  = |look_vec;
  assign any_valid = |vld;
  assign st_ready  = hit || (|free_vec);
  assign st_fire   = st_valid && st_ready;
  assign do_alloc  = st_fire && !hit;
  assign st_onehot = WORDS'(1) << st_word;
  assign new_rank  = IDX_W'(cnt_valid - CNT_W'(free_en));
  assign tgt_idx   = hit ? hit_idx : alloc_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        rank_q[i] <= '0;
        blk_q[i]  <= '0;
        msk_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (free_en && (drain_idx == IDX_W'(i)))
          vld[i] <= 1'b0;
        else if (vld[i] && free_en && (rank_q[i] > rank_q[drain_idx]))
          rank_q[i] <= rank_q[i] - 1'b1;
        if (do_alloc && (alloc_idx == IDX_W'(i))) begin
          vld[i]    <= 1'b1;
          blk_q[i]  <= st_blk;
          msk_q[i]  <= st_onehot;
          rank_q[i] <= new_rank;
        end else if (st_fire && hit && (hit_idx == IDX_W'(i))) begin
          msk_q[i] <= msk_q[i] | st_onehot;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st_fire) dat_q[{tgt_idx, st_word}] <= st_data;
  end

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_out
      assign out_block[w*DATA_W +: DATA_W] = dat_q[{out_idx, OFF_W'(w)}];
    end
  endgenerate
  assign out_blk  = blk_q[out_idx];
  assign out_mask = msk_q[out_idx];

  // two mergeable entries never share a block
  logic dup_blk;
  always_comb begin
    dup_blk = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (vld[i] && vld[j] && (blk_q[i] == blk_q[j]) &&
            !(drain_busy && (drain_idx == IDX_W'(i) || drain_idx == IDX_W'(j))))
          dup_blk = 1'b1;
  end

  p_block_unique_r2: assert property (@(posedge clk) disable iff (rst)
    !dup_blk);

  p_oldest_unique_r6: assert property (@(posedge clk) disable iff (rst)
    any_valid |-> $onehot(head_vec));
endmodule

// File: rtl/wbm_memctl.sv
module wbm_memctl
  import wbm_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int WORDS   = 4,
  parameter int DATA_W  = 32,
  parameter int BADDR_W = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_req,
  input  logic [BADDR_W-1:0]      rd_addr,
  input  logic                    any_valid,
  input  logic [IDX_W-1:0]        oldest_idx,
  input  logic                    look_hit,
  input  logic [IDX_W-1:0]        look_idx,
  input  logic                    mem_ack,
  input  logic [WORDS*DATA_W-1:0] mem_rdata,
  output logic                    drain_busy,
  output logic [IDX_W-1:0]        drain_idx,
  output logic                    free_en,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [BADDR_W-1:0]      rd_blk_q,
  output logic                    rd_done,
  output logic [WORDS*DATA_W-1:0] rd_data
);
  mstate_t          st_q;
  logic [IDX_W-1:0] idx_q;
  logic             want_rd;

  // a request still high in the pulse cycle belongs to the finished read
  assign want_rd    = rd_req && !rd_done;
  assign drain_busy = (st_q == MS_WR);
  assign drain_idx  = idx_q;
  assign free_en    = (st_q == MS_WR) && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= MS_IDLE;
      idx_q    <= '0;
      rd_blk_q <= '0;
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      rd_done  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_done <= 1'b0;
      case (st_q)
        MS_IDLE: begin
          if (want_rd && look_hit) begin
            st_q <= MS_WR; idx_q <= look_idx; mem_req <= 1'b1; mem_we <= 1'b1;
          end else if (want_rd) begin
            st_q <= MS_RD; rd_blk_q <= rd_addr; mem_req <= 1'b1; mem_we <= 1'b0;
          end else if (any_valid) begin
            st_q <= MS_WR; idx_q <= oldest_idx; mem_req <= 1'b1; mem_we <= 1'b1;
          end
        end
        MS_WR: if (mem_ack) begin
          st_q <= MS_IDLE; mem_req <= 1'b0;
        end
        MS_RD: if (mem_ack) begin
          st_q <= MS_IDLE; mem_req <= 1'b0; rd_done <= 1'b1; rd_data <= mem_rdata;
        end
        default: st_q <= MS_IDLE;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);
endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4,
  parameter int WORDS   = 4,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int BADDR_W = ADDR_W - OFF_W,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [DATA_W-1:0]       st_data,
  input  logic                    rd_req,
  input  logic [BADDR_W-1:0]      rd_addr,
  output logic                    rd_done,
  output logic [WORDS*DATA_W-1:0] rd_data,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [BADDR_W-1:0]      mem_addr,
  output logic [WORDS*DATA_W-1:0] mem_wdata,
  output logic [WORDS-1:0]        mem_wmask,
  input  logic                    mem_ack,
  input  logic [WORDS*DATA_W-1:0] mem_rdata
);
  logic               drain_busy, free_en, look_hit, any_valid;
  logic [IDX_W-1:0]   drain_idx, look_idx, oldest_idx;
  logic [BADDR_W-1:0] ent_blk, rd_blk_q;

  wbm_store #(.ENTRIES(ENTRIES), .WORDS(WORDS), .DATA_W(DATA_W), .BADDR_W(BADDR_W)) u_store (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_blk(st_addr[ADDR_W-1:OFF_W]), .st_word(st_addr[OFF_W-1:0]),
    .st_data(st_data), .st_ready(st_ready),
    .drain_busy(drain_busy), .drain_idx(drain_idx), .free_en(free_en),
    .look_blk(rd_addr), .look_hit(look_hit), .look_idx(look_idx),
    .any_valid(any_valid), .oldest_idx(oldest_idx),
    .out_idx(drain_idx), .out_blk(ent_blk), .out_block(mem_wdata), .out_mask(mem_wmask)
  );

  wbm_memctl #(.ENTRIES(ENTRIES), .WORDS(WORDS), .DATA_W(DATA_W), .BADDR_W(BADDR_W)) u_memctl (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .any_valid(any_valid), .oldest_idx(oldest_idx),
    .look_hit(look_hit), .look_idx(look_idx),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .drain_busy(drain_busy), .drain_idx(drain_idx), .free_en(free_en),
    .mem_req(mem_req), .mem_we(mem_we), .rd_blk_q(rd_blk_q),
    .rd_done(rd_done), .rd_data(rd_data)
  );

  assign mem_addr = mem_we ? ent_blk : rd_blk_q;

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  p_drain_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !mem_ack) |=> ($stable(mem_wdata) && $stable(mem_wmask)));
endmodule

// File: tb/wbuf_merge_tb.sv
module wbuf_merge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 64;

  logic         clk = 1'b0;
  logic         rst;
  logic         st_valid;
  logic         st_ready;
  logic [7:0]   st_addr;
  logic [31:0]  st_data;
  logic         rd_req;
  logic [5:0]   rd_addr;
  logic         rd_done;
  logic [127:0] rd_data;
  logic         mem_req, mem_we, mem_ack;
  logic [5:0]   mem_addr;
  logic [127:0] mem_wdata, mem_rdata;
  logic [3:0]   mem_wmask;

  wbuf_merge u_dut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_data(rd_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem_arr [NBLK][4];
  logic [31:0] gold    [NBLK][4];
  int          checks = 0, failures = 0;
  logic        ack_en;
  int          lat, cnt;
  logic [6:0]  tr_code [32];
  logic [3:0]  tr_mask [32];
  int          tr_n;

  function automatic logic [6:0] code(input logic we, input int b);
    return {we, 6'(b)};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model, answers at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0; cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; cnt = 0;
    end else if (mem_req && ack_en) begin
      if (cnt >= lat) begin
        mem_ack = 1'b1;
        if (tr_n < 32) begin
          tr_code[tr_n] = {mem_we, mem_addr};
          tr_mask[tr_n] = mem_we ? mem_wmask : 4'h0;
        end
        tr_n++;
        if (mem_we) begin
          for (int w = 0; w < 4; w++)
            if (mem_wmask[w]) mem_arr[mem_addr][w] = mem_wdata[w*32 +: 32];
        end else begin
          for (int w = 0; w < 4; w++) mem_rdata[w*32 +: 32] = mem_arr[mem_addr][w];
        end
      end else cnt++;
    end
  end

  task automatic store(input int b, input int w, input logic [31:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = {6'(b), 2'(w)}; st_data = d;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    gold[b][w] = d;
    #1 st_valid = 1'b0;
  endtask

  task automatic probe(input int b, input int w, output logic rdy);
    @(negedge clk);
    st_valid = 1'b1; st_addr = {6'(b), 2'(w)}; st_data = 32'hDEAD_BEEF;
    #1 rdy = st_ready;
    st_valid = 1'b0;
  endtask

  task automatic do_read(input int b, output logic [127:0] got);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 6'(b);
    #1;
    while (!rd_done) begin @(negedge clk); #1; end
    got = rd_data;
    rd_req = 1'b0;
    @(negedge clk); #1;
    chk("R10 rd_done single pulse", {127'd0, rd_done}, 128'd0);
  endtask

  function automatic logic [127:0] gold_blk(input int b);
    logic [127:0] r;
    for (int w = 0; w < 4; w++) r[w*32 +: 32] = gold[b][w];
    return r;
  endfunction

  task automatic settle();
    repeat (80) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic rdy;
    logic [127:0] got;
    logic [15:0] lfsr;
    for (int b = 0; b < NBLK; b++)
      for (int w = 0; w < 4; w++) begin
        mem_arr[b][w] = 32'hA000_0000 | 32'(b << 8) | 32'(w);
        gold[b][w]    = mem_arr[b][w];
      end
    rst = 1'b1; st_valid = 1'b0; st_addr = '0; st_data = '0;
    rd_req = 1'b0; rd_addr = '0; ack_en = 1'b1; lat = 1; tr_n = 0;
    mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R1 st_ready after reset", {127'd0, st_ready}, 128'd1);
    chk("R1 mem_req after reset", {127'd0, mem_req}, 128'd0);
    chk("R1 rd_done after reset", {127'd0, rd_done}, 128'd0);

    // merge, and no merge into the draining entry (R2, R4, R6)
    ack_en = 1'b0; tr_n = 0;
    store(5, 0, 32'h1111_0000);
    for (int w = 0; w < 4; w++) store(7, w, 32'h7700_0000 + 32'(w));
    store(5, 1, 32'h1111_0001);
    ack_en = 1'b1; settle();
    chk("R6 write count", 128'(tr_n), 128'd3);
    chk("R6 first drain blk5", {121'd0, tr_code[0]}, {121'd0, code(1, 5)});
    chk("R2 merged blk7 one write", {121'd0, tr_code[1]}, {121'd0, code(1, 7)});
    chk("R2 merged mask", {124'd0, tr_mask[1]}, 128'hF);
    chk("R4 separate write blk5", {121'd0, tr_code[2]}, {121'd0, code(1, 5)});
    chk("R4 second mask", {124'd0, tr_mask[2]}, 128'h2);
    chk("R2 memory blk7", {mem_arr[7][3], mem_arr[7][2], mem_arr[7][1], mem_arr[7][0]}, gold_blk(7));
    chk("R4 memory blk5", {mem_arr[5][3], mem_arr[5][2], mem_arr[5][1], mem_arr[5][0]}, gold_blk(5));

    // full buffer stall (R5)
    ack_en = 1'b0; tr_n = 0;
    for (int b = 10; b < 14; b++) store(b, 0, 32'hB000_0000 + 32'(b));
    probe(14, 0, rdy);
    chk("R5 stall when full", {127'd0, rdy}, 128'd0);
    probe(12, 2, rdy);
    chk("R5 merge allowed when full", {127'd0, rdy}, 128'd1);
    probe(10, 1, rdy);
    chk("R5 draining block stalls", {127'd0, rdy}, 128'd0);
    store(12, 2, 32'hC12C_0002);
    ack_en = 1'b1;
    store(14, 0, 32'hB000_000E);
    settle();
    chk("R6 full test count", 128'(tr_n), 128'd5);
    for (int k = 0; k < 5; k++)
      chk("R6 oldest-first order", {121'd0, tr_code[k]}, {121'd0, code(1, 10 + k)});
    chk("R2 mask words 0,2", {124'd0, tr_mask[2]}, 128'h5);

    // overwrite of a pending word (R3)
    ack_en = 1'b0; tr_n = 0;
    store(20, 0, 32'h2020_0000);
    store(21, 3, 32'hAAAA_AAAA);
    store(21, 3, 32'hBBBB_BBBB);
    ack_en = 1'b1; settle();
    chk("R3 last value wins", {96'd0, mem_arr[21][3]}, 128'hBBBB_BBBB);
    chk("R3 single write mask", {124'd0, tr_mask[1]}, 128'h8);

    // read overtakes queued writes (R7)
    ack_en = 1'b0; tr_n = 0;
    for (int b = 30; b < 33; b++) store(b, 0, 32'h3000_0000 + 32'(b));
    fork
      do_read(40, got);
      begin repeat (4) @(negedge clk); ack_en = 1'b1; end
    join
    chk("R7 read data", got, gold_blk(40));
    settle();
    chk("R7 in-flight write first", {121'd0, tr_code[0]}, {121'd0, code(1, 30)});
    chk("R7 read before queued", {121'd0, tr_code[1]}, {121'd0, code(0, 40)});
    chk("R7 queued after read a", {121'd0, tr_code[2]}, {121'd0, code(1, 31)});
    chk("R7 queued after read b", {121'd0, tr_code[3]}, {121'd0, code(1, 32)});

    // read hits a buffered block (R8)
    ack_en = 1'b0; tr_n = 0;
    store(33, 0, 32'h3333_0000);
    store(34, 1, 32'h3434_0001);
    store(35, 2, 32'h3535_5A5A);
    fork
      do_read(35, got);
      begin repeat (4) @(negedge clk); ack_en = 1'b1; end
    join
    chk("R8 read sees buffered store", got, gold_blk(35));
    settle();
    chk("R8 order drain current", {121'd0, tr_code[0]}, {121'd0, code(1, 33)});
    chk("R8 order drain hit", {121'd0, tr_code[1]}, {121'd0, code(1, 35)});
    chk("R8 order read", {121'd0, tr_code[2]}, {121'd0, code(0, 35)});
    chk("R8 order rest", {121'd0, tr_code[3]}, {121'd0, code(1, 34)});

    // sweep over memory latencies with mixed stores and reads (R8, R11)
    lfsr = 16'hACE1;
    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int n = 0; n < 24; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        store(48 + int'(lfsr[2:0]), int'(lfsr[4:3]), {lfsr, 8'(l), 8'(n)});
        if (n % 6 == 5) begin
          do_read(48 + int'(lfsr[7:5]), got);
          chk("R8 sweep read", got, gold_blk(48 + int'(lfsr[7:5])));
        end
      end
    end
    settle();
    for (int b = 0; b < NBLK; b++)
      chk("R11 final memory image",
          {mem_arr[b][3], mem_arr[b][2], mem_arr[b][1], mem_arr[b][0]}, gold_blk(b));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule